// File: doc/BRIEF.md
# Dual-Mode Serial Clock Divider

This block derives a serial bit clock from the module clock for a serial shift engine. One configuration word picks one of two division schemes: a linear even divider, where the serial clock period is 2*(N+1) module cycles, or a power-of-two divider, where the period is 2^N module cycles. Besides the clock level, the block raises a one-cycle strobe on each rising and each falling transition of the serial clock. A shifter can use these strobes to launch and capture data without sampling the level itself.

A run input gates the clock. While run is low the clock sits at its idle level, which is low. When run rises, the first transition follows one half-period later. A write of the configuration word restarts the divider from the idle state, so no shortened or stretched period appears at a change of rate.

Top module: `sclk_div_gen`

## Requirements
- R1: After reset `sclk_o`, `rise_o` and `fall_o` are all low. The configuration holds zero, which is exponent mode with exponent zero.
- R2: With bit 12 of the configuration set (linear mode), each high phase and each low phase of `sclk_o` lasts N2+1 module cycles. N2 is bits 7:0, so the duty cycle is 50 percent.
- R3: With bit 12 clear (exponent mode) and exponent N1 (bits 11:8) of at least 1, each phase of `sclk_o` lasts 2^(N1-1) module cycles.
- R4: In exponent mode, N1 = 0 gives the fastest usable rate: each phase lasts one module cycle, which is half the module clock, the same as N1 = 1.
- R5: While `run_i` is low, `sclk_o` stays low and no strobe fires. After `run_i` rises, the first transition is a rise, one half-period of run-high cycles later.
- R6: `rise_o` pulses for one cycle together with each 0-to-1 change of `sclk_o`, and `fall_o` with each 1-to-0 change. The two never fire together. Outside a restart, `sclk_o` changes only with a strobe.
- R7: A configuration write (`cfg_we_i` high) drives `sclk_o` low with no strobe in the next cycle, whatever the current phase. The first transition then comes one half-period of the new setting later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | Enables the serial clock; low holds it idle |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 13 | Configuration word: [7:0] linear value, [11:8] exponent, [12] mode (1 linear, 0 exponent) |
| sclk_o | output | 1 | Serial clock level, idle low |
| rise_o | output | 1 | One-cycle strobe with each rising transition |
| fall_o | output | 1 | One-cycle strobe with each falling transition |

## Verification
The bench builds the block with its default widths: an 8-bit linear field and a 4-bit exponent field. With these widths both ends of each range can be reached. In linear mode that is a half-period from 1 up to 256 cycles. In exponent mode it is the clamped zero exponent up to the largest exponent, whose 16384-cycle phase is measured in full. Random settings cover the middle of both ranges, with exponents kept small enough to keep the run short. Directed sequences cover run dropping in mid-phase and a rate change while the clock is high.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
  typedef enum logic {
    MODE_EXP = 1'b0,
    MODE_LIN = 1'b1
  } div_mode_e;

  function automatic int max_int(int a, int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sdiv_cfg_reg.sv
module sdiv_cfg_reg
  import sdiv_pkg::*;
#(
  parameter int LIN_W = 8,
  parameter int EXP_W = 4,
  localparam int CFG_W = LIN_W + EXP_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output logic [LIN_W-1:0] lin_n_o,
  output logic [EXP_W-1:0] exp_n_o,
  output div_mode_e        mode_o
);
  logic [CFG_W-1:0] cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= '0;
    else if (we_i) cfg_q <= wdata_i;
  end

  assign lin_n_o = cfg_q[LIN_W-1:0];
  assign exp_n_o = cfg_q[LIN_W +: EXP_W];
  assign mode_o  = div_mode_e'(cfg_q[CFG_W-1]);
endmodule

// File: rtl/sdiv_half_calc.sv
module sdiv_half_calc
  import sdiv_pkg::*;
#(
  parameter int LIN_W = 8,
  parameter int EXP_W = 4,
  parameter int CNT_W = 15
) (
  input  logic [LIN_W-1:0] lin_n_i,
  input  logic [EXP_W-1:0] exp_n_i,
  input  div_mode_e        mode_i,
  output logic [CNT_W-1:0] half_m1_o
);
  logic [EXP_W-1:0] shift;
  logic [CNT_W-1:0] pow_half;

  // exponent 0 clamps to exponent 1: half of the module clock is the ceiling
  assign shift    = (exp_n_i == '0) ? '0 : exp_n_i - EXP_W'(1);
  assign pow_half = CNT_W'(1) << shift;

  always_comb begin
    if (mode_i == MODE_LIN) half_m1_o = CNT_W'(lin_n_i);
    else                    half_m1_o = pow_half - CNT_W'(1);
  end
endmodule

// File: rtl/sdiv_counter.sv
module sdiv_counter #(
  parameter int CNT_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] half_m1_i,
  output logic             sclk_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             sclk_q, rise_q, fall_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else if (restart_i || !run_i) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else if (cnt_q >= half_m1_i) begin
      cnt_q  <= '0;
      sclk_q <= ~sclk_q;
      rise_q <= ~sclk_q;
      fall_q <= sclk_q;
    end else begin
      cnt_q  <= cnt_q + CNT_W'(1);
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end
  end

  assign sclk_o = sclk_q;
  assign rise_o = rise_q;
  assign fall_o = fall_q;
endmodule

// File: rtl/sclk_div_gen.sv
module sclk_div_gen
  import sdiv_pkg::*;
#(
  parameter int LIN_W = 8,
  parameter int EXP_W = 4,
  localparam int CFG_W = LIN_W + EXP_W + 1,
  localparam int CNT_W = max_int(LIN_W + 1, (1 << EXP_W) - 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  output logic             sclk_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [LIN_W-1:0] lin_n;
  logic [EXP_W-1:0] exp_n;
  div_mode_e        mode;
  logic [CNT_W-1:0] half_m1;

  sdiv_cfg_reg #(.LIN_W(LIN_W), .EXP_W(EXP_W)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .lin_n_o (lin_n),
    .exp_n_o (exp_n),
    .mode_o  (mode)
  );

  sdiv_half_calc #(.LIN_W(LIN_W), .EXP_W(EXP_W), .CNT_W(CNT_W)) u_half (
    .lin_n_i   (lin_n),
    .exp_n_i   (exp_n),
    .mode_i    (mode),
    .half_m1_o (half_m1)
  );

  sdiv_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run_i),
    .restart_i (cfg_we_i),
    .half_m1_i (half_m1),
    .sclk_o    (sclk_o),
    .rise_o    (rise_o),
    .fall_o    (fall_o)
  );
endmodule

// File: rtl/sdiv_checker.sv
module sdiv_checker #(
  parameter int LIN_W = 8,
  parameter int EXP_W = 4,
  localparam int CFG_W = LIN_W + EXP_W + 1,
  localparam int GAP_W = (1 << EXP_W) + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run_i,
  input logic             cfg_we_i,
  input logic [CFG_W-1:0] cfg_wdata_i,
  input logic             sclk_o,
  input logic             rise_o,
  input logic             fall_o
);
  logic [CFG_W-1:0] shadow_q;
  logic [GAP_W-1:0] gap_q;
  logic [GAP_W-1:0] exp_half;
  logic [EXP_W-1:0] e_val;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       shadow_q <= '0;
    else if (cfg_we_i) shadow_q <= cfg_wdata_i;
  end

  assign e_val = shadow_q[LIN_W +: EXP_W];

  always_comb begin
    if (shadow_q[CFG_W-1])  exp_half = GAP_W'(shadow_q[LIN_W-1:0]) + GAP_W'(1);
    else if (e_val == '0)   exp_half = GAP_W'(1);
    else                    exp_half = GAP_W'(1) << (e_val - EXP_W'(1));
  end

  // run-high cycles since the last strobe or restart
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     gap_q <= '0;
    else if (cfg_we_i || !run_i)     gap_q <= '0;
    else if (rise_o || fall_o)       gap_q <= GAP_W'(1);
    else if (gap_q != '1)            gap_q <= gap_q + GAP_W'(1);
  end

  // R2 R4: the same window check covers both modes
  p_half_period_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_o || fall_o) |-> gap_q == exp_half);

  p_idle_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (!sclk_o && !rise_o && !fall_o));

  p_strobe_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rise_o, fall_o}));

  p_rise_level_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |-> (sclk_o && !$past(sclk_o)));

  p_fall_level_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |-> (!sclk_o && $past(sclk_o)));

  p_no_silent_change_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rise_o && !fall_o && $past(run_i) && !$past(cfg_we_i)) |-> $stable(sclk_o));

  p_restart_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> (!sclk_o && !rise_o && !fall_o));
endmodule

bind sclk_div_gen sdiv_checker #(.LIN_W(LIN_W), .EXP_W(EXP_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .run_i       (run_i),
  .cfg_we_i    (cfg_we_i),
  .cfg_wdata_i (cfg_wdata_i),
  .sclk_o      (sclk_o),
  .rise_o      (rise_o),
  .fall_o      (fall_o)
);

// File: tb/sclk_div_gen_bench.sv
module sclk_div_gen_bench;
  localparam int LIN_W = 8;
  localparam int EXP_W = 4;
  localparam int CFG_W = LIN_W + EXP_W + 1;
  localparam int LIMIT = 40000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0;
  logic we = 1'b0;
  logic [CFG_W-1:0] wdata = '0;
  logic sclk, rise, fall;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  sclk_div_gen #(.LIN_W(LIN_W), .EXP_W(EXP_W)) u_sclk_div_gen (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .cfg_we_i(we),
    .cfg_wdata_i(wdata), .sclk_o(sclk), .rise_o(rise), .fall_o(fall)
  );

  function automatic logic [CFG_W-1:0] lin_cfg(int n2);
    return {1'b1, EXP_W'(0), LIN_W'(n2)};
  endfunction

  function automatic logic [CFG_W-1:0] exp_cfg(int n1);
    return {1'b0, EXP_W'(n1), LIN_W'(0)};
  endfunction

  function automatic int half_of(logic [CFG_W-1:0] c);
    int e;
    if (c[CFG_W-1]) return int'(c[LIN_W-1:0]) + 1;
    e = int'(c[LIN_W +: EXP_W]);
    return (e == 0) ? 1 : (1 << (e - 1));
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_strobe(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!(rise || fall) && n < LIMIT);
  endtask

  task automatic write_cfg(logic [CFG_W-1:0] c, bit keep_run);
    @(negedge clk);
    wdata = c;
    we = 1'b1;
    run = keep_run;
    @(negedge clk);
    we = 1'b0;
  endtask

  // write, raise run, measure first (rising) and second (falling) phase
  task automatic run_cfg(logic [CFG_W-1:0] c, string req);
    int n, h;
    h = half_of(c);
    write_cfg(c, 1'b0);
    run = 1'b1;
    wait_strobe(n);
    check(n == h && rise && !fall && sclk, {req, " R5 first rise"}, n, h);
    wait_strobe(n);
    check(n == h && fall && !rise && !sclk, {req, " second phase fall R6"}, n, h);
    @(negedge clk);
    run = 1'b0;
  endtask

  initial begin
    int n;
    bit idle_ok;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(!sclk && !rise && !fall, "R1 reset outputs", int'({sclk, rise, fall}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!sclk && !rise && !fall, "R1 after release", int'({sclk, rise, fall}), 0);

    run_cfg(lin_cfg(0), "R2 lin0");
    run_cfg(lin_cfg(255), "R2 lin255");
    run_cfg(lin_cfg(7), "R2 lin7");
    run_cfg(exp_cfg(0), "R4 exp0");
    run_cfg(exp_cfg(1), "R3 exp1");
    run_cfg(exp_cfg(5), "R3 exp5");
    run_cfg(exp_cfg(15), "R3 exp15");

    for (int i = 0; i < 10; i++) begin
      if ($urandom_range(1, 0) == 1) run_cfg(lin_cfg(int'($urandom_range(255, 0))), "R2 rand");
      else run_cfg(exp_cfg(int'($urandom_range(9, 0))), "R3 rand");
    end

    // R5: drop run in mid-phase, then resume
    write_cfg(lin_cfg(3), 1'b0);
    run = 1'b1;
    wait_strobe(n);
    repeat (2) @(negedge clk);
    run = 1'b0;
    idle_ok = 1'b1;
    repeat (20) begin
      @(negedge clk);
      if (sclk || rise || fall) idle_ok = 1'b0;
    end
    check(idle_ok, "R5 idle while run low", int'(idle_ok), 1);
    run = 1'b1;
    wait_strobe(n);
    check(n == 4 && rise, "R5 resume first rise", n, 4);

    // R7: rate change while clock is high
    write_cfg(lin_cfg(9), 1'b0);
    run = 1'b1;
    wait_strobe(n);
    check(sclk == 1'b1, "R7 setup high", int'(sclk), 1);
    repeat (3) @(negedge clk);
    wdata = lin_cfg(2);
    we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    check(!sclk && !rise && !fall, "R7 restart idle", int'({sclk, rise, fall}), 0);
    wait_strobe(n);
    check(n == 3 && rise, "R7 new rate first rise", n, 3);
    wait_strobe(n);
    check(n == 3 && fall, "R7 new rate fall", n, 3);
    run = 1'b0;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule